// File: doc/BRIEF.md
# Two-Level Latching Interrupt Controller

This block gathers a parameterised group of user interrupt lines and turns them into a single processor interrupt. Every user line first passes through its own optional inverter and then through a conditioner chosen per line: a transparent path, a sample-and-hold latch, or a rising-edge catcher. A user-side enable masks the conditioned bits. The masked bits are then placed next to a small group of internal interrupt sources in a 32-bit device status word.

A device-side enable turns the status word into a pending vector. A priority encoder reports the lowest pending index. A global enable then gates the OR of the pending bits onto a registered processor interrupt. Every configuration and status word can be reached through a plain synchronous register port. Writes take effect at the rising clock edge. Read data is combinational from the address. The port never stalls, so it has no back-pressure; all pins are plain control or status signals without a valid/ready handshake.

Top module: `irq_ctrl_top`

## Requirements
- R1: When a user bit's mode field is 0 (or the unused code 3), its user status bit follows the conditioned level (input XOR inversion bit) in the same cycle and holds no state.
- R2: Setting bit k of the inversion register (address 3) inverts user input k before it is conditioned.
- R3: With mode 1 (sample-and-hold), a conditioned level of 1 at a rising clock edge sets the user status bit, and the bit stays set until it is cleared.
- R4: With mode 2 (edge capture), the user status bit is set at an edge where the conditioned level is 1 and was 0 at the previous edge; a level that stays high does not set the bit again after a clear. Out of reset the previous level counts as 1.
- R5: Writing 1 to bit k of the user status register (address 0) clears a latched bit k; if a set event happens in the same cycle, the bit stays set.
- R6: Device status bit NUM_INT+k equals user status bit k AND user enable bit k (address 1).
- R7: Device status bits [NUM_INT-1:0] pass the internal sources through unlatched; the device status bits above NUM_INT+NUM_USR-1 read 0 (address 4).
- R8: The pending vector (address 6) is device status AND the device enable register (address 5).
- R9: The processor interrupt equals the global enable (address 8, bit 0) AND the OR of the pending vector, registered one clock later.
- R10: The ID register (address 7) reads the lowest pending bit index, or all-ones when nothing is pending.
- R11: After reset, all enables, modes, inversions and latches are 0, the processor interrupt is 0, and the ID reads all-ones.
- R12: The mode register (address 2) holds two bits per user line, line k in bits [2k+1:2k]. The writable configuration registers read back their written values within their implemented width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_irq_i | input | NUM_USR | User interrupt lines |
| int_irq_i | input | NUM_INT | Internal interrupt sources, level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| cpu_irq_o | output | 1 | Registered processor interrupt |

## Verification
A latch that is wrongly set or stuck shows up at the user status and pending reads in the same cycle. It reaches the processor interrupt one edge later, and the ID word moves to the wrong index at once. A broken edge detector shows up as a bit that fails to set after a low-to-high step, or as a bit that sets again after a clear while the line is still held high. Both cases are visible on the read right after the next edge. A wrong priority or a wrong merge position shows up as a wrong ID or a wrong status word on the first read with that input pattern.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_EDGE = 2'd2,
    MODE_RSVD = 2'd3
  } irq_mode_e;

  localparam int DEV_W = 32;

  localparam int A_USTAT = 0;
  localparam int A_UEN   = 1;
  localparam int A_UMODE = 2;
  localparam int A_UINV  = 3;
  localparam int A_DSTAT = 4;
  localparam int A_DEN   = 5;
  localparam int A_DPEND = 6;
  localparam int A_DID   = 7;
  localparam int A_GCTL  = 8;

  localparam logic [31:0] ID_NONE = 32'hFFFF_FFFF;
endpackage

// File: rtl/irq_bit_cond.sv
module irq_bit_cond
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      raw_i,
  input  logic      inv_i,
  input  irq_mode_e mode_i,
  input  logic      clr_i,
  output logic      stat_o
);
  logic lvl;
  logic prev_q;
  logic lat_q;
  logic set_ev;
  logic latching;

  assign lvl      = raw_i ^ inv_i;
  assign latching = (mode_i == MODE_HOLD) || (mode_i == MODE_EDGE);

  always_comb begin
    unique case (mode_i)
      MODE_HOLD: set_ev = lvl;
      MODE_EDGE: set_ev = lvl & ~prev_q;
      default:   set_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (!latching) lat_q <= 1'b0;
      else           lat_q <= set_ev | (lat_q & ~clr_i);
    end
  end

  assign stat_o = latching ? lat_q : lvl;

  a_r3_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (latching && lat_q && !clr_i) |=> lat_q);

  a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_EDGE && !prev_q && lvl) |=> lat_q);

  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_HOLD && lvl && clr_i) |=> lat_q);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  pend_i,
  output logic [IW-1:0] id_o,
  output logic          any_o
);
  always_comb begin
    id_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend_i[i]) id_o = IW'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irqc_pkg::*;
#(
  parameter int NUM_USR = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [NUM_USR-1:0]   uen_o,
  output logic [NUM_USR-1:0]   uinv_o,
  output logic [2*NUM_USR-1:0] umode_o,
  output logic [DEV_W-1:0]     den_o,
  output logic                 gie_o,
  output logic [NUM_USR-1:0]   uclr_o
);
  logic hit_uen, hit_uinv, hit_umode, hit_den, hit_gctl, hit_ustat;

  assign hit_ustat = wr_i && (addr_i == ADDR_W'(A_USTAT));
  assign hit_uen   = wr_i && (addr_i == ADDR_W'(A_UEN));
  assign hit_umode = wr_i && (addr_i == ADDR_W'(A_UMODE));
  assign hit_uinv  = wr_i && (addr_i == ADDR_W'(A_UINV));
  assign hit_den   = wr_i && (addr_i == ADDR_W'(A_DEN));
  assign hit_gctl  = wr_i && (addr_i == ADDR_W'(A_GCTL));

  assign uclr_o = hit_ustat ? wdata_i[NUM_USR-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uen_o   <= '0;
      uinv_o  <= '0;
      umode_o <= '0;
      den_o   <= '0;
      gie_o   <= 1'b0;
    end else begin
      if (hit_uen)   uen_o   <= wdata_i[NUM_USR-1:0];
      if (hit_uinv)  uinv_o  <= wdata_i[NUM_USR-1:0];
      if (hit_umode) umode_o <= wdata_i[2*NUM_USR-1:0];
      if (hit_den)   den_o   <= wdata_i[DEV_W-1:0];
      if (hit_gctl)  gie_o   <= wdata_i[0];
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irqc_pkg::*;
#(
  parameter int NUM_USR = 8,
  parameter int NUM_INT = 4,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_USR-1:0] usr_irq_i,
  input  logic [NUM_INT-1:0] int_irq_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               cpu_irq_o
);
  localparam int IW      = $clog2(DEV_W);
  localparam int USR_LSB = NUM_INT;

  logic [NUM_USR-1:0]   uen, uinv, uclr, ustat;
  logic [2*NUM_USR-1:0] umode;
  logic [DEV_W-1:0]     den, dstat, pend;
  logic                 gie;
  logic [IW-1:0]        id;
  logic                 any;
  logic                 irq_q;

  irq_cfg_regs #(.NUM_USR(NUM_USR), .ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .uen_o(uen), .uinv_o(uinv), .umode_o(umode),
    .den_o(den), .gie_o(gie), .uclr_o(uclr)
  );

  for (genvar k = 0; k < NUM_USR; k++) begin : g_cond
    irq_bit_cond cond_i (
      .clk(clk), .rst_n(rst_n), .raw_i(usr_irq_i[k]), .inv_i(uinv[k]),
      .mode_i(irq_mode_e'(umode[2*k +: 2])), .clr_i(uclr[k]),
      .stat_o(ustat[k])
    );
  end

  always_comb begin
    dstat = '0;
    dstat[NUM_INT-1:0] = int_irq_i;
    dstat[USR_LSB +: NUM_USR] = ustat & uen;
  end

  assign pend = dstat & den;

  irq_prio_enc #(.W(DEV_W)) enc_i (.pend_i(pend), .id_o(id), .any_o(any));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gie & any;
  end
  assign cpu_irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(A_USTAT): reg_rdata_o[NUM_USR-1:0]   = ustat;
      ADDR_W'(A_UEN):   reg_rdata_o[NUM_USR-1:0]   = uen;
      ADDR_W'(A_UMODE): reg_rdata_o[2*NUM_USR-1:0] = umode;
      ADDR_W'(A_UINV):  reg_rdata_o[NUM_USR-1:0]   = uinv;
      ADDR_W'(A_DSTAT): reg_rdata_o = dstat;
      ADDR_W'(A_DEN):   reg_rdata_o = den;
      ADDR_W'(A_DPEND): reg_rdata_o = pend;
      ADDR_W'(A_DID):   reg_rdata_o = any ? 32'(id) : ID_NONE;
      ADDR_W'(A_GCTL):  reg_rdata_o[0] = gie;
      default:          reg_rdata_o = '0;
    endcase
  end

  a_r9_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o |-> $past(gie));

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && |pend) |=> cpu_irq_o);

  a_r10_id_pending: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend[id]);

  a_r10_id_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((pend & ((32'd1 << id) - 32'd1)) == '0));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dstat >> (NUM_INT + NUM_USR)) == '0);
endmodule

// File: tb/irq_ctrl_top_tb_top.sv
module irq_ctrl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  usr_irq = '0;
  logic [3:0]  int_irq = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_ctrl_top #(.NUM_USR(8), .NUM_INT(4), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .usr_irq_i(usr_irq), .int_irq_i(int_irq),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .cpu_irq_o(cpu_irq)
  );

  typedef struct packed {
    logic [7:0]  usr;
    logic [3:0]  intr;
    logic [7:0]  inv;
    logic [7:0]  uen;
    logic [11:0] den;
    logic [11:0] stat;
    logic [11:0] pend;
    logic [31:0] id;
  } vec_t;

  localparam vec_t TBL [0:6] = '{
    '{8'h00, 4'h0, 8'h00, 8'hFF, 12'hFFF, 12'h000, 12'h000, 32'hFFFF_FFFF},
    '{8'h05, 4'h0, 8'h00, 8'hFF, 12'hFFF, 12'h050, 12'h050, 32'd4},
    '{8'h05, 4'h8, 8'h00, 8'hFE, 12'hFFF, 12'h048, 12'h048, 32'd3},
    '{8'h00, 4'h0, 8'h80, 8'hFF, 12'hFFF, 12'h800, 12'h800, 32'd11},
    '{8'hF0, 4'h3, 8'h0F, 8'hFF, 12'hF00, 12'hFF3, 12'hF00, 32'd8},
    '{8'h0F, 4'h2, 8'h00, 8'h0F, 12'h002, 12'h0F2, 12'h002, 32'd1},
    '{8'hFF, 4'hF, 8'hFF, 8'hFF, 12'hFFF, 12'h00F, 12'h00F, 32'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    rd(4'd0, v); chk("R11 ustat", v, 32'h0);
    rd(4'd1, v); chk("R11 uen", v, 32'h0);
    rd(4'd2, v); chk("R11 umode", v, 32'h0);
    rd(4'd4, v); chk("R11 dstat", v, 32'h0);
    rd(4'd7, v); chk("R11 id", v, 32'hFFFF_FFFF);
    chk("R11 irq", {31'b0, cpu_irq}, 32'h0);

    // Table walk: pass-through mode on all lines (R1 R2 R6 R7 R8 R10 R9)
    wr(4'd8, 32'h1);
    for (int i = 0; i < 7; i++) begin
      wr(4'd3, {24'b0, TBL[i].inv});
      wr(4'd1, {24'b0, TBL[i].uen});
      wr(4'd5, {20'b0, TBL[i].den});
      usr_irq = TBL[i].usr;
      int_irq = TBL[i].intr;
      rd(4'd0, v); chk("R1 R2 ustat", v, {24'b0, TBL[i].usr ^ TBL[i].inv});
      rd(4'd4, v); chk("R6 R7 dstat", v, {20'b0, TBL[i].stat});
      rd(4'd6, v); chk("R8 pend", v, {20'b0, TBL[i].pend});
      rd(4'd7, v); chk("R10 id", v, TBL[i].id);
      @(negedge clk); @(negedge clk);
      chk("R9 irq level", {31'b0, cpu_irq}, {31'b0, TBL[i].pend != 0});
    end

    // R9 timing and gating
    usr_irq = '0; int_irq = '0;
    wr(4'd8, 32'h0);
    wr(4'd3, 32'h0);
    wr(4'd1, 32'hFF);
    wr(4'd5, 32'hFFF);
    usr_irq = 8'h01;
    @(negedge clk); @(negedge clk);
    chk("R9 gated off", {31'b0, cpu_irq}, 32'h0);
    wr(4'd8, 32'h1);
    chk("R9 one-cycle delay", {31'b0, cpu_irq}, 32'h0);
    @(negedge clk);
    chk("R9 asserted", {31'b0, cpu_irq}, 32'h1);
    usr_irq = 8'h00;
    #1;
    chk("R9 still registered", {31'b0, cpu_irq}, 32'h1);
    @(negedge clk);
    chk("R9 drops", {31'b0, cpu_irq}, 32'h0);

    // R3 sample-and-hold on line 0
    wr(4'd2, 32'h1);
    usr_irq = 8'h01;
    @(negedge clk);
    usr_irq = 8'h00;
    rd(4'd0, v); chk("R3 held after pulse", v, 32'h1);
    rd(4'd7, v); chk("R3 R10 id", v, 32'd4);
    @(negedge clk);
    rd(4'd0, v); chk("R3 still held", v, 32'h1);
    wr(4'd0, 32'h1);
    rd(4'd0, v); chk("R5 cleared", v, 32'h0);
    // R5 set wins over clear
    usr_irq = 8'h01;
    @(negedge clk);
    wr(4'd0, 32'h1);
    rd(4'd0, v); chk("R5 set beats clear", v, 32'h1);
    usr_irq = 8'h00;
    wr(4'd0, 32'h1);
    rd(4'd0, v); chk("R5 clear after drop", v, 32'h0);

    // R4 edge capture on line 1
    wr(4'd2, 32'h8);
    @(negedge clk);
    usr_irq = 8'h02;
    @(negedge clk);
    rd(4'd0, v); chk("R4 edge set", v, 32'h2);
    wr(4'd0, 32'h2);
    rd(4'd0, v); chk("R4 no reset while high", v, 32'h0);
    @(negedge clk);
    rd(4'd0, v); chk("R4 stays clear", v, 32'h0);
    usr_irq = 8'h00;
    @(negedge clk);
    usr_irq = 8'h02;
    @(negedge clk);
    rd(4'd0, v); chk("R4 second edge", v, 32'h2);
    wr(4'd0, 32'h2);
    // R2 inversion feeding the edge detector: line high, inverted level low
    wr(4'd3, 32'h2);
    @(negedge clk);
    rd(4'd0, v); chk("R2 R4 inverted no edge", v, 32'h0);
    usr_irq = 8'h00;
    @(negedge clk);
    rd(4'd0, v); chk("R2 R4 inverted edge", v, 32'h2);

    // R12 readback and R7 upper bits
    wr(4'd2, 32'hFFFF_A5A5);
    rd(4'd2, v); chk("R12 umode width", v, 32'h0000_A5A5);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, v); chk("R12 den", v, 32'hFFFF_FFFF);
    int_irq = 4'hF; usr_irq = 8'hFF; wr(4'd3, 32'h0);
    rd(4'd4, v); chk("R7 upper zero", v & 32'hFFFF_F000, 32'h0);

    finish_run();
  end
endmodule